// File: doc/BRIEF.md
# Divergence-Driven Split/Fuse Controller

This controller sits beside one pair of execution clusters that can run either as one wide fused cluster or as two independent halves. While the pair is fused, warps found to be divergent are reported one at a time, and their IDs are collected in a small bin. When a split is requested, the controller compares the share of divergent warps against a programmable fraction of the resident warp count. If the share is strictly larger, the controller leaves fused operation and streams every binned warp ID, one per cycle, to the secondary cluster.

While the pair is split, each half runs its own warps. Caches, register files and the network port stay shared; the controller does not touch them. The controller counts the slow half's stall cycles over a programmable window. When a window ends with more stalls than a limit, it hands one fast warp ID across so that the slow half has work. When the secondary cluster reports that all migrated warps have completed, the pair passes through a one-cycle re-fuse state and returns to fused operation with an empty bin. Each pair has its own controller, so fused and split pairs can coexist.

Top module: `warp_split_ctrl`

## Requirements
- R1: After reset `fused` is 1, and `mig_valid` and `topup_valid` are 0.
- R2: A `split_req` seen while fused causes a split only if (bin count × 16) > (`thresh` × `total_warps`). Equality does not split, and `fused` stays 1.
- R3: Divergence reports (`div_valid` with `div_wid`) enter the bin only while fused. Reports made in any other state are discarded, so after re-fusing the bin starts empty.
- R4: The bin holds at most 16 warp IDs. Reports made while it is full are dropped.
- R5: On a split, `fused` goes low in the cycle after the request. From that same cycle, `mig_valid` is high for exactly as many consecutive cycles as there are binned IDs, and `mig_wid` presents them in arrival order.
- R6: A `split_req` that arrives while the bin is empty is ignored, for any `thresh`.
- R7: While split, a high `sec_all_done` moves the pair to re-fuse, and `fused` returns to 1 two cycles later.
- R8: While split, the controller counts `slow_stall` cycles over each window of `period` cycles. If a window ends with a count greater than `stall_limit`, `topup_valid` pulses for one cycle in the next cycle, and `topup_wid` carries the `fast_wid` sampled at the end of the window.
- R9: `mig_valid` and `topup_valid` are never high while `fused` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh | input | 4 | Split threshold in sixteenths of the resident warp count |
| total_warps | input | CNT_W | Resident warps in the fused cluster |
| div_valid | input | 1 | A divergent warp is reported this cycle |
| div_wid | input | WID_W | ID of the reported warp |
| split_req | input | 1 | Evaluate the split condition this cycle |
| sec_all_done | input | 1 | Secondary cluster has finished all migrated warps |
| period | input | PER_W | Stall-check window length in cycles (0 disables) |
| stall_limit | input | PER_W | Stall count that a window must exceed to trigger a top-up |
| slow_stall | input | 1 | Slow cluster stalled this cycle |
| fast_wid | input | WID_W | Fast warp ID offered for top-up |
| fused | output | 1 | Pair operates as one fused cluster |
| mig_valid | output | 1 | A binned warp ID is migrating this cycle |
| mig_wid | output | WID_W | Migrating warp ID |
| topup_valid | output | 1 | A fast warp is moved to the slow cluster |
| topup_wid | output | WID_W | ID of the moved fast warp |

## Verification
A corrupted bin pointer or count shows up at the ports during the next migration. The burst then has the wrong length, or IDs appear out of arrival order, within one bin's worth of cycles after the split. A wrong state register shows up as `fused` or `mig_valid` moving in the wrong cycle, one cycle after the triggering input. Errors in the stall window appear as top-up pulses at the wrong rate, and they surface within one window. The bench therefore counts pulses over whole windows instead of checking single cycles.

// File: rtl/warp_split_ctrl.sv
module warp_split_ctrl #(
  parameter int WID_W = 5,
  parameter int DEPTH = 16,
  parameter int CNT_W = 6,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       thresh,
  input  logic [CNT_W-1:0] total_warps,
  input  logic             div_valid,
  input  logic [WID_W-1:0] div_wid,
  input  logic             split_req,
  input  logic             sec_all_done,
  input  logic [PER_W-1:0] period,
  input  logic [PER_W-1:0] stall_limit,
  input  logic             slow_stall,
  input  logic [WID_W-1:0] fast_wid,
  output logic             fused,
  output logic             mig_valid,
  output logic [WID_W-1:0] mig_wid,
  output logic             topup_valid,
  output logic [WID_W-1:0] topup_wid
);
  localparam int AW = $clog2(DEPTH);
  localparam int MW = ((CNT_W > AW + 1) ? CNT_W : AW + 1) + 4;

  typedef enum logic [1:0] {S_FUSED, S_DRAIN, S_SPLIT, S_REFUSE} st_t;
  st_t st;

  logic [WID_W-1:0] bin [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt;
  logic [PER_W-1:0] per_cnt, stl_cnt;

  wire push = (st == S_FUSED) && div_valid && (cnt != (AW+1)'(DEPTH));
  wire pop  = (st == S_DRAIN);
  wire over = (MW'(cnt) << 4) > (MW'(thresh) * MW'(total_warps));
  wire go   = (st == S_FUSED) && split_req && (cnt != '0) && over;

  wire [PER_W:0] stl_sum = {1'b0, stl_cnt} + {{PER_W{1'b0}}, slow_stall};
  wire per_end = (st == S_SPLIT) && (period != '0) && (per_cnt == period - 1'b1);

  assign fused     = (st == S_FUSED);
  assign mig_valid = pop;
  assign mig_wid   = bin[rp];

  always_ff @(posedge clk)
    if (push) bin[wp] <= div_wid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (push)     cnt <= cnt + 1'b1;
      else if (pop) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_FUSED;
    else begin
      case (st)
        S_FUSED:  if (go) st <= S_DRAIN;
        S_DRAIN:  if (cnt == (AW+1)'(1)) st <= S_SPLIT;
        S_SPLIT:  if (sec_all_done) st <= S_REFUSE;
        default:  st <= S_FUSED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_cnt     <= '0;
      stl_cnt     <= '0;
      topup_valid <= 1'b0;
      topup_wid   <= '0;
    end else begin
      topup_valid <= per_end && (stl_sum > {1'b0, stall_limit});
      if (per_end) topup_wid <= fast_wid;
      if (st != S_SPLIT || per_end) begin
        per_cnt <= '0;
        stl_cnt <= '0;
      end else begin
        per_cnt <= per_cnt + 1'b1;
        stl_cnt <= stl_sum[PER_W-1:0];
      end
    end
  end
endmodule

module warp_split_ctrl_chk #(
  parameter int DEPTH = 16
) (
  input logic clk,
  input logic rst_n,
  input logic split_req,
  input logic sec_all_done,
  input logic fused,
  input logic mig_valid,
  input logic topup_valid
);
  logic [$clog2(DEPTH)+1:0] mig_seen;

  always_ff @(posedge clk) begin
    if (!rst_n || fused) mig_seen <= '0;
    else if (mig_valid)  mig_seen <= mig_seen + 1'b1;
  end

  assert_split_on_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fused) |-> $past(split_req));
  assert_bin_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mig_seen <= ($clog2(DEPTH)+2)'(DEPTH));
  assert_no_mig_fused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mig_valid |-> !fused);
  assert_refuse_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fused) |-> $past(sec_all_done, 2));
  assert_no_topup_fused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    topup_valid |-> !fused);
endmodule

bind warp_split_ctrl warp_split_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .split_req(split_req), .sec_all_done(sec_all_done),
  .fused(fused), .mig_valid(mig_valid), .topup_valid(topup_valid)
);

// File: tb/tb_warp_split_ctrl.sv
`timescale 1ns/1ps
module tb_warp_split_ctrl;
  logic       clk = 0, rst_n = 0;
  logic [3:0] thresh = 0;
  logic [5:0] total_warps = 8;
  logic       div_valid = 0, split_req = 0, sec_all_done = 0, slow_stall = 0;
  logic [4:0] div_wid = 0, fast_wid = 5'd9;
  logic [7:0] period = 8'd4, stall_limit = 8'd2;
  logic       fused, mig_valid, topup_valid;
  logic [4:0] mig_wid, topup_wid;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  warp_split_ctrl dut (.*);

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic push(input int id);
    div_valid = 1; div_wid = 5'(id); step(); div_valid = 0;
  endtask

  task automatic request(); split_req = 1; step(); split_req = 0; endtask

  task automatic refuse();
    sec_all_done = 1; step(); sec_all_done = 0;
    check("R7 re-fuse state not fused", fused, 0);
    step();
    check("R7 fused again", fused, 1);
  endtask

  task automatic t_reset();
    check("R1 fused", fused, 1);
    check("R1 mig_valid", mig_valid, 0);
    check("R1 topup_valid", topup_valid, 0);
  endtask

  task automatic t_empty();
    thresh = 0; request();
    check("R6 empty bin stays fused", fused, 1);
    check("R6 no migration", mig_valid, 0);
  endtask

  task automatic t_ratio_and_migrate();
    int ids[5] = '{3, 7, 1, 12, 30};
    thresh = 8; total_warps = 8;
    for (int i = 0; i < 4; i++) push(ids[i]);
    request();
    check("R2 equal ratio stays fused", fused, 1);
    check("R2 equal ratio no migration", mig_valid, 0);
    push(ids[4]);
    request();
    check("R5 fused low after split", fused, 0);
    for (int i = 0; i < 5; i++) begin
      check("R5 mig_valid during burst", mig_valid, 1);
      check("R5 migration order", mig_wid, ids[i]);
      step();
    end
    check("R5 burst length", mig_valid, 0);
    check("R5 still split", fused, 0);
  endtask

  task automatic t_topup(input int mode, input int exp, input string tag);
    int seen = 0;
    for (int i = 0; i < 24; i++) begin
      case (mode)
        0: slow_stall = 0;
        1: slow_stall = 1;
        2: slow_stall = i[0];
        default: slow_stall = (i % 4) != 0;
      endcase
      step();
      if (i >= 8 && topup_valid) begin
        seen++;
        check("R8 topup_wid", topup_wid, 9);
      end
    end
    slow_stall = 0;
    check(tag, seen, exp);
  endtask

  task automatic t_ignore_while_split();
    push(4); push(5);
    refuse();
    thresh = 0; request();
    check("R3 reports during split discarded", fused, 1);
    push(20); request();
    check("R3 fresh bin migrates", mig_valid, 1);
    check("R3 fresh bin id", mig_wid, 20);
    step();
    check("R3 fresh bin holds one", mig_valid, 0);
    refuse();
  endtask

  task automatic t_full();
    int n = 0, first = -1, last = -1;
    thresh = 0; total_warps = 32;
    for (int i = 0; i < 17; i++) push(i);
    request();
    while (mig_valid && n < 40) begin
      if (first < 0) first = mig_wid;
      last = mig_wid; n++; step();
    end
    check("R4 bin capacity", n, 16);
    check("R4 first id", first, 0);
    check("R4 last kept id", last, 15);
    refuse();
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_empty();
    t_ratio_and_migrate();
    t_topup(1, 4, "R8 all stalls: four top-ups in 16 cycles");
    t_topup(0, 0, "R8 no stalls: no top-up");
    t_topup(2, 0, "R8 stalls equal limit: no top-up");
    t_topup(3, 4, "R8 three of four stalls: four top-ups");
    t_ignore_while_split();
    t_full();
    check("R9 topup absent when fused", topup_valid, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule